// File: doc/BRIEF.md
# Half-Bridge Command Interlock with Timed Sleep

This block sits between a controller's two gate commands (one for the high side of a half-bridge, one for the low side) and the enables of the two gate drivers. While the block is awake, each command reaches its own driver enable without inversion. When both commands are high at once, both enables are held low. An undervoltage flag forces both enables low and turns on the low side's strong pull-down.

The block also has a low-power sleep state. Holding both commands high for a set number of cycles puts it to sleep, and so does an undervoltage flag that stays up for long enough. Only one pattern wakes it: high-side command low and low-side command high, held for a set time while the undervoltage flag is clear. While asleep, the high-side output asks for high impedance and the low side is actively held down.

The three inputs are asynchronous and pass through synchronizers before any decision logic uses them. The block does not insert dead time; that stays the controller's job. Reset puts the block into sleep.

Top module: `hb_cmd_guard`

## Requirements
- R1: While awake with the undervoltage flag clear, `hs_drv` equals `hi_cmd` and `ls_drv` equals `lo_cmd` (no inversion), provided the other command is low. A command change on the pins reaches the enable on the second rising clock edge after the change.
- R2: Whenever both synchronized commands are high, `hs_drv` and `ls_drv` are both 0.
- R3: If one command is high and the other then rises, the second enable stays 0 until the first command falls. When one command falls and the other rises together, one enable falls and the other rises on the same edge, with no gap inserted.
- R4: Both commands held high enters sleep. `sleep_flag` rises on rising edge SET_CYCLES+2 after the pins change and is still 0 one edge earlier.
- R5: The both-high interval counter restarts from zero if the condition is broken for a single cycle.
- R6: Sleep is left only by holding `hi_cmd`=0 and `lo_cmd`=1. `sleep_flag` falls on edge CLR_CYCLES+2 after that pattern appears. Both low, high-side only, or both high, held for any length of time, leave the block asleep.
- R7: While the synchronized undervoltage flag is 1, both enables are 0 and `ls_pulldown` is 1.
- R8: An undervoltage flag held continuously enters sleep on edge UV_CYCLES+2 after it rises. A shorter pulse does not.
- R9: Sleep cannot be left while the undervoltage flag is 1. The wake interval starts counting only once the synchronized flag has cleared.
- R10: While asleep, `hs_hiz`=1, `ls_pulldown`=1, `hs_drv`=0 and `ls_drv`=0.
- R11: During and after reset, the block is asleep (`sleep_flag`=1, `hs_hiz`=1, `ls_pulldown`=1) with both enables 0.
- R12: In the first cycle after `sleep_flag` falls, both enables stay 0. Pass-through resumes on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd | input | 1 | High-side command, asynchronous |
| lo_cmd | input | 1 | Low-side command, asynchronous |
| uv_flag | input | 1 | Supply undervoltage indication, asynchronous, active high |
| hs_drv | output | 1 | High-side driver enable |
| ls_drv | output | 1 | Low-side driver enable |
| hs_hiz | output | 1 | Request for high impedance on the high-side output |
| ls_pulldown | output | 1 | Request for the strong pull-down on the low-side output |
| sleep_flag | output | 1 | Block is asleep |

## Verification
The bench measures the exact edge on which sleep is entered and left. A timer that is off by one, or a synchronizer with the wrong depth, moves that edge and is caught. It breaks the both-high interval for one cycle and then checks the entry edge again; a counter that pauses instead of restarting would reach sleep early. It holds the wrong patterns and a live undervoltage flag for long stretches during sleep; a design that woke on any pattern other than the one above, or ignored the flag during wake-up, would drop `sleep_flag`. It also checks the blanking cycle after wake-up and the same-edge hand-over between the two sides. Missing blanking would let an enable rise one cycle early, and added dead time would leave both enables low for a cycle.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  // Next sleep state: asleep only wakes on the wake timer, awake sleeps on either entry timer.
  function automatic logic sleep_next(input logic asleep, input logic set_hit,
                                      input logic uv_hit, input logic clr_hit);
    if (asleep) return !clr_hit;
    return set_hit | uv_hit;
  endfunction

  // One side may drive when permitted, commanded, and the opposite command is low.
  function automatic logic side_enable(input logic allow, input logic mine, input logic other);
    return allow & mine & ~other;
  endfunction

  // Width of a counter reaching limit-1.
  function automatic int cnt_width(input int limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbd_hold_timer.sv
module hbd_hold_timer
  import hbd_pkg::*;
#(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic fire
);
  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!cond)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign fire = cond && (cnt == LAST);

  // R5: a single broken cycle clears the count
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> (cnt == '0));

  // R4: firing needs the condition to have been present on the previous cycle too
  a_r4_fire_held: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(cond));
endmodule

// File: rtl/hbd_gate_logic.sv
module hbd_gate_logic
  import hbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic asleep,
  input  logic blank,
  input  logic uv,
  input  logic hi,
  input  logic lo,
  output logic hs_en,
  output logic ls_en,
  output logic hiz_req,
  output logic pd_req
);
  logic allow;

  assign allow   = !asleep && !blank && !uv;
  assign hs_en   = side_enable(allow, hi, lo);
  assign ls_en   = side_enable(allow, lo, hi);
  assign hiz_req = asleep;
  assign pd_req  = asleep | uv;

  a_r2_both_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && lo) |-> (!hs_en && !ls_en));

  a_r7_uv_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    uv |-> (!hs_en && !ls_en && pd_req));

  a_r10_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!hs_en && !ls_en && hiz_req && pd_req));
endmodule

// File: rtl/hb_cmd_guard.sv
module hb_cmd_guard
  import hbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SET_CYCLES  = 5000,
  parameter int CLR_CYCLES  = 5000,
  parameter int UV_CYCLES   = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd,
  input  logic uv_flag,
  output logic hs_drv,
  output logic ls_drv,
  output logic hs_hiz,
  output logic ls_pulldown,
  output logic sleep_flag
);
  localparam int NSIG = 3;
  localparam int IDX_HI = 2;
  localparam int IDX_LO = 1;
  localparam int IDX_UV = 0;

  logic [NSIG-1:0] raw_in, sync_in;
  logic hi_s, lo_s, uv_s;
  logic set_cond, clr_cond;
  logic set_fire, clr_fire, uv_fire;
  logic sleep_q, blank_q;

  assign raw_in = {hi_cmd, lo_cmd, uv_flag};

  hbd_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  assign hi_s = sync_in[IDX_HI];
  assign lo_s = sync_in[IDX_LO];
  assign uv_s = sync_in[IDX_UV];

  assign set_cond = hi_s && lo_s;
  assign clr_cond = !hi_s && lo_s && !uv_s;

  hbd_hold_timer #(.LIMIT(SET_CYCLES)) u_set_tmr (
    .clk(clk), .rst_n(rst_n), .cond(set_cond), .fire(set_fire)
  );
  hbd_hold_timer #(.LIMIT(CLR_CYCLES)) u_clr_tmr (
    .clk(clk), .rst_n(rst_n), .cond(clr_cond), .fire(clr_fire)
  );
  hbd_hold_timer #(.LIMIT(UV_CYCLES)) u_uv_tmr (
    .clk(clk), .rst_n(rst_n), .cond(uv_s), .fire(uv_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b1;
      blank_q <= 1'b0;
    end else begin
      sleep_q <= sleep_next(sleep_q, set_fire, uv_fire, clr_fire);
      blank_q <= sleep_q && clr_fire;
    end
  end

  hbd_gate_logic u_gate (
    .clk(clk), .rst_n(rst_n),
    .asleep(sleep_q), .blank(blank_q), .uv(uv_s), .hi(hi_s), .lo(lo_s),
    .hs_en(hs_drv), .ls_en(ls_drv), .hiz_req(hs_hiz), .pd_req(ls_pulldown)
  );

  assign sleep_flag = sleep_q;

  a_r4_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> $past(set_fire || uv_fire));

  a_r6_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> $past(clr_fire));

  a_r9_no_wake_in_uv: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && uv_s) |=> sleep_q);

  a_r12_wake_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> (!hs_drv && !ls_drv));
endmodule

// File: tb/tb_hb_cmd_guard.sv
module tb_hb_cmd_guard;
  localparam int SETC = 16;
  localparam int CLRC = 12;
  localparam int UVC  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_cmd = 1'b0, lo_cmd = 1'b0, uv_flag = 1'b0;
  logic hs_drv, ls_drv, hs_hiz, ls_pulldown, sleep_flag;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hb_cmd_guard #(.SYNC_STAGES(2), .SET_CYCLES(SETC), .CLR_CYCLES(CLRC), .UV_CYCLES(UVC)) dut (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .uv_flag(uv_flag),
    .hs_drv(hs_drv), .ls_drv(ls_drv), .hs_hiz(hs_hiz), .ls_pulldown(ls_pulldown),
    .sleep_flag(sleep_flag)
  );

  typedef struct packed {
    logic hi; logic lo; logic uv;
    logic e_hs; logic e_ls; logic e_pd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0},  // R1 idle
    '{1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0},  // R1 high side passes
    '{1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0},  // R2 R3 low rises second
    '{1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0},  // R3 first drops, second passes
    '{1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0},  // R3 high rises second
    '{1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0},  // R3 low drops, high passes
    '{1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0},  // R1 low side passes
    '{1'b0,1'b1,1'b1, 1'b0,1'b0,1'b1},  // R7 short undervoltage
    '{1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1},  // R7
    '{1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0},  // R8 short pulse leaves block awake
    '{1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}   // R1
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input logic h, input logic l, input logic u);
    hi_cmd = h; lo_cmd = l; uv_flag = u;
  endtask

  task automatic wake();
    pins(1'b0, 1'b1, 1'b0);
    edges(CLRC + 4);
    chk("R6", "wake helper sleep_flag", sleep_flag, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    // R11 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "sleep_flag in reset", sleep_flag, 1'b1);
    chk("R11", "hs_hiz in reset", hs_hiz, 1'b1);
    chk("R11", "ls_pulldown in reset", ls_pulldown, 1'b1);
    chk("R11", "hs_drv in reset", hs_drv, 1'b0);
    chk("R11", "ls_drv in reset", ls_drv, 1'b0);
    rst_n = 1'b1;
    edges(4);
    chk("R11", "sleep_flag after reset", sleep_flag, 1'b1);

    // R6 wrong patterns keep sleep; R10 outputs while asleep
    pins(1'b0, 1'b0, 1'b0); edges(3 * CLRC);
    chk("R6", "both low keeps sleep", sleep_flag, 1'b1);
    pins(1'b1, 1'b0, 1'b0); edges(3 * CLRC);
    chk("R6", "high only keeps sleep", sleep_flag, 1'b1);
    chk("R10", "hs_drv asleep", hs_drv, 1'b0);
    chk("R10", "hs_hiz asleep", hs_hiz, 1'b1);
    pins(1'b1, 1'b1, 1'b0); edges(3 * CLRC);
    chk("R6", "both high keeps sleep", sleep_flag, 1'b1);

    // R6 exact wake edge, R12 blank cycle
    pins(1'b0, 1'b1, 1'b0);
    edges(CLRC + 1);
    chk("R6", "still asleep one edge early", sleep_flag, 1'b1);
    chk("R10", "ls_drv asleep", ls_drv, 1'b0);
    chk("R10", "ls_pulldown asleep", ls_pulldown, 1'b1);
    edges(1);
    chk("R6", "awake on edge CLR+2", sleep_flag, 1'b0);
    chk("R12", "ls_drv blanked first awake cycle", ls_drv, 1'b0);
    chk("R10", "hs_hiz released", hs_hiz, 1'b0);
    edges(1);
    chk("R12", "ls_drv resumes next cycle", ls_drv, 1'b1);

    // Vector table walk while awake
    for (int v = 0; v < NV; v++) begin
      pins(VT[v].hi, VT[v].lo, VT[v].uv);
      edges(2);
      chk("R1", $sformatf("vec %0d hs_drv", v), hs_drv, VT[v].e_hs);
      chk("R1", $sformatf("vec %0d ls_drv", v), ls_drv, VT[v].e_ls);
      chk("R7", $sformatf("vec %0d ls_pulldown", v), ls_pulldown, VT[v].e_pd);
      chk("R8", $sformatf("vec %0d sleep_flag", v), sleep_flag, 1'b0);
    end

    // R1 latency and R3 same-edge hand-over
    pins(1'b1, 1'b0, 1'b0); edges(3);
    chk("R1", "hs_drv on", hs_drv, 1'b1);
    pins(1'b0, 1'b1, 1'b0); edges(1);
    chk("R1", "hs_drv held one edge after change", hs_drv, 1'b1);
    chk("R3", "ls_drv not yet", ls_drv, 1'b0);
    edges(1);
    chk("R3", "hs_drv off on edge 2", hs_drv, 1'b0);
    chk("R3", "ls_drv on same edge", ls_drv, 1'b1);

    // R4 exact entry edge
    pins(1'b1, 1'b1, 1'b0);
    edges(SETC + 1);
    chk("R4", "not asleep at SET+1", sleep_flag, 1'b0);
    edges(1);
    chk("R4", "asleep at SET+2", sleep_flag, 1'b1);
    chk("R4", "hs_hiz at entry", hs_hiz, 1'b1);

    // R5 restart after a one-cycle break
    wake();
    pins(1'b1, 1'b1, 1'b0); edges(SETC - 2);
    pins(1'b1, 1'b0, 1'b0); edges(1);
    pins(1'b1, 1'b1, 1'b0);
    edges(SETC + 1);
    chk("R5", "count restarted, no sleep at SET+1", sleep_flag, 1'b0);
    edges(1);
    chk("R5", "sleep at SET+2 after restart", sleep_flag, 1'b1);

    // R7, R8, R9 undervoltage
    wake();
    pins(1'b1, 1'b0, 1'b0); edges(3);
    chk("R7", "hs_drv on before undervoltage", hs_drv, 1'b1);
    pins(1'b1, 1'b0, 1'b1); edges(2);
    chk("R7", "hs_drv forced low", hs_drv, 1'b0);
    chk("R7", "ls_pulldown on", ls_pulldown, 1'b1);
    chk("R7", "still awake", sleep_flag, 1'b0);
    edges(UVC - 1);
    chk("R8", "not asleep at UV+1", sleep_flag, 1'b0);
    edges(1);
    chk("R8", "asleep at UV+2", sleep_flag, 1'b1);
    pins(1'b0, 1'b1, 1'b1); edges(3 * CLRC);
    chk("R9", "wake pattern ignored under undervoltage", sleep_flag, 1'b1);
    chk("R9", "ls_drv stays low", ls_drv, 1'b0);
    pins(1'b0, 1'b1, 1'b0);
    edges(CLRC + 1);
    chk("R9", "wake counts from flag clear", sleep_flag, 1'b1);
    edges(1);
    chk("R9", "awake at CLR+2 after flag clear", sleep_flag, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule